// File: doc/BRIEF.md
# Accumulator Processor with Interrupt Cycle

This block is a small multicycle processor whose only working register is an accumulator. Code and data share one word-addressed memory reached through a synchronous port. Each 16-bit instruction has a 4-bit opcode in bits 15..12 and a 12-bit word address in bits 11..0, which gives 4096 words. The sequencer carries out every instruction as a chain of single register transfers. These pass through a memory address register and a memory buffer register, and one transfer happens per clock.

When an instruction has finished, the sequencer looks at a level-sensitive interrupt request. If the request is high and interrupts are enabled, it saves the return address and the accumulator to two fixed words at the top of memory and then jumps to a fixed handler entry. A dedicated return opcode reloads both saved values. The block is meant to be wired to a single-port synchronous RAM. After reset, execution starts at word 0x064.

Top module: `acc_cpu`

## Requirements
- R1: While reset is low, `halted`, `mem_re` and `mem_we` are all low. The first memory access after reset is a read of word 0x064.
- R2: Each instruction is fetched by a read at the program counter. The next fetch reads the program counter plus one, unless a jump or an interrupt changes it.
- R3: Opcode 0101 (load) reads the word at its address field and puts that word into the accumulator.
- R4: Opcode 0001 (add) reads the word at its address field and adds it to the accumulator, modulo 2^16.
- R5: Opcode 0010 (store) writes the accumulator to the word at its address field. The program 0x5068, 0x1069, 0x206A, 0x0000 at 100..103, with 3 at 104 and 5 at 105, leaves 8 at 106.
- R6: Opcode 0000 (stop) raises `halted`. From then on no memory access takes place until reset.
- R7: Opcode 0110 (jump) makes the next fetch read the word at its address field.
- R8: The interrupt request is sampled only after an instruction completes, and only while interrupts are enabled. When it is taken, the block writes the return address, zero-extended, to 0xFFE, then writes the accumulator to 0xFFF, then fetches from 0x010.
- R9: Taking an interrupt disables further interrupts. A request held high during the handler is not taken again before the return.
- R10: Opcode 0111 (return) reads 0xFFE and then 0xFFF. It restores the program counter and the accumulator from those two words, and it enables interrupts again.
- R11: The opcodes not listed above do nothing. They make no operand access, they leave the accumulator unchanged, and fetching continues at the next word.
- R12: `mem_re` and `mem_we` are never high in the same cycle. Read data is taken one cycle after the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| irq | input | 1 | Level interrupt request |
| mem_addr | output | 12 | Memory word address |
| mem_re | output | 1 | Read request; data is expected on `mem_rdata` in the next cycle |
| mem_we | output | 1 | Write strobe for `mem_wdata` at `mem_addr` |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data from the synchronous memory |
| halted | output | 1 | High once a stop instruction has executed |

## Verification
The bench predicts the complete stream of memory accesses, in order, and compares every read or write against that prediction.

The first program runs load, add, store and stop with no interrupt. It separates the fetch path from the operand path, and it shows that the port falls silent after the stop.

The second program holds the request high from the first cycle. A nop, a jump and a handler that overwrites the accumulator follow. This shows four things:
- the request waits for the first instruction to finish;
- the save order is correct;
- the handler is not re-entered while interrupts are disabled;
- the return brings back the old accumulator rather than the handler's value.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int OPC_W = 4;

    localparam logic [OPC_W-1:0] OPC_STOP  = 4'b0000;
    localparam logic [OPC_W-1:0] OPC_ADD   = 4'b0001;
    localparam logic [OPC_W-1:0] OPC_STORE = 4'b0010;
    localparam logic [OPC_W-1:0] OPC_MOVE  = 4'b0101;
    localparam logic [OPC_W-1:0] OPC_JUMP  = 4'b0110;
    localparam logic [OPC_W-1:0] OPC_RETI  = 4'b0111;

    typedef enum logic [2:0] {
        CLS_STOP, CLS_ADD, CLS_STORE, CLS_MOVE, CLS_JUMP, CLS_RETI, CLS_NOP
    } op_cls_e;

    typedef enum logic {ALU_PASS, ALU_ADD} alu_sel_e;

    typedef enum logic [4:0] {
        S_F_MAR, S_F_REQ, S_F_MBR, S_F_INC, S_F_IR, S_DEC,
        S_E_MAR, S_E_REQ, S_E_MBR, S_E_ALU,
        S_S_MAR, S_S_MBR, S_S_WR,
        S_J_PC,
        S_R_MAR0, S_R_REQ0, S_R_MBR0, S_R_PC,
        S_R_MAR1, S_R_REQ1, S_R_MBR1, S_R_AC,
        S_CHK,
        S_I_MAR0, S_I_MBR0, S_I_WR0, S_I_MAR1, S_I_MBR1, S_I_WR1, S_I_VEC,
        S_HALT
    } seq_st_e;

endpackage

// File: rtl/acc_cpu_decode.sv
module acc_cpu_decode
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12
) (
    input  logic [DATA_W-1:0] ir,
    output op_cls_e           op_cls,
    output logic [ADDR_W-1:0] op_addr
);
    logic [OPC_W-1:0] opc;

    always_comb begin
        opc     = ir[DATA_W-1 -: OPC_W];
        op_addr = ir[ADDR_W-1:0];
        case (opc)
            OPC_STOP:  op_cls = CLS_STOP;
            OPC_ADD:   op_cls = CLS_ADD;
            OPC_STORE: op_cls = CLS_STORE;
            OPC_MOVE:  op_cls = CLS_MOVE;
            OPC_JUMP:  op_cls = CLS_JUMP;
            OPC_RETI:  op_cls = CLS_RETI;
            default:   op_cls = CLS_NOP;
        endcase
    end
endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  alu_sel_e          sel,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] opnd,
    output logic [DATA_W-1:0] res
);
    always_comb begin
        case (sel)
            ALU_ADD: res = acc + opnd;
            default: res = opnd;
        endcase
    end
endmodule

// File: rtl/acc_cpu_seq.sv
module acc_cpu_seq
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12,
    parameter logic [ADDR_W-1:0] RESET_PC = 12'h064,
    parameter logic [ADDR_W-1:0] HANDLER  = 12'h010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq,
    input  op_cls_e           op_cls,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [DATA_W-1:0] alu_res,
    output alu_sel_e          alu_sel,
    output logic [DATA_W-1:0] ir_o,
    output logic [DATA_W-1:0] ac_o,
    output logic [DATA_W-1:0] mbr_o,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_re,
    output logic              mem_we,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              halted
);
    localparam logic [ADDR_W-1:0] SAVE_PC = ADDR_W'((2 ** ADDR_W) - 2);
    localparam logic [ADDR_W-1:0] SAVE_AC = ADDR_W'((2 ** ADDR_W) - 1);
    localparam int PAD_W = DATA_W - ADDR_W;

    typedef struct packed {
        seq_st_e           st;
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] mar;
        logic [DATA_W-1:0] mbr;
        logic [DATA_W-1:0] ir;
        logic [DATA_W-1:0] ac;
        logic              ie;
    } seq_t;

    seq_t r_q, r_d;

    always_comb begin
        r_d     = r_q;
        alu_sel = ALU_PASS;
        mem_re  = 1'b0;
        mem_we  = 1'b0;
        case (r_q.st)
            S_F_MAR:  begin r_d.mar = r_q.pc;               r_d.st = S_F_REQ; end
            S_F_REQ:  begin mem_re = 1'b1;                   r_d.st = S_F_MBR; end
            S_F_MBR:  begin r_d.mbr = mem_rdata;             r_d.st = S_F_INC; end
            S_F_INC:  begin r_d.pc = r_q.pc + 1'b1;          r_d.st = S_F_IR;  end
            S_F_IR:   begin r_d.ir = r_q.mbr;                r_d.st = S_DEC;   end
            S_DEC: begin
                case (op_cls)
                    CLS_STOP:           r_d.st = S_HALT;
                    CLS_MOVE, CLS_ADD:  r_d.st = S_E_MAR;
                    CLS_STORE:          r_d.st = S_S_MAR;
                    CLS_JUMP:           r_d.st = S_J_PC;
                    CLS_RETI:           r_d.st = S_R_MAR0;
                    default:            r_d.st = S_CHK;
                endcase
            end
            S_E_MAR:  begin r_d.mar = op_addr;               r_d.st = S_E_REQ; end
            S_E_REQ:  begin mem_re = 1'b1;                   r_d.st = S_E_MBR; end
            S_E_MBR:  begin r_d.mbr = mem_rdata;             r_d.st = S_E_ALU; end
            S_E_ALU: begin
                alu_sel = (op_cls == CLS_ADD) ? ALU_ADD : ALU_PASS;
                r_d.ac  = alu_res;
                r_d.st  = S_CHK;
            end
            S_S_MAR:  begin r_d.mar = op_addr;               r_d.st = S_S_MBR; end
            S_S_MBR:  begin r_d.mbr = r_q.ac;                r_d.st = S_S_WR;  end
            S_S_WR:   begin mem_we = 1'b1;                   r_d.st = S_CHK;   end
            S_J_PC:   begin r_d.pc = op_addr;                r_d.st = S_CHK;   end
            S_R_MAR0: begin r_d.mar = SAVE_PC;               r_d.st = S_R_REQ0; end
            S_R_REQ0: begin mem_re = 1'b1;                   r_d.st = S_R_MBR0; end
            S_R_MBR0: begin r_d.mbr = mem_rdata;             r_d.st = S_R_PC;   end
            S_R_PC:   begin r_d.pc = r_q.mbr[ADDR_W-1:0];    r_d.st = S_R_MAR1; end
            S_R_MAR1: begin r_d.mar = SAVE_AC;               r_d.st = S_R_REQ1; end
            S_R_REQ1: begin mem_re = 1'b1;                   r_d.st = S_R_MBR1; end
            S_R_MBR1: begin r_d.mbr = mem_rdata;             r_d.st = S_R_AC;   end
            S_R_AC:   begin r_d.ac = r_q.mbr; r_d.ie = 1'b1; r_d.st = S_CHK;    end
            S_CHK:    r_d.st = (irq && r_q.ie) ? S_I_MAR0 : S_F_MAR;
            S_I_MAR0: begin r_d.mar = SAVE_PC;                     r_d.st = S_I_MBR0; end
            S_I_MBR0: begin r_d.mbr = {{PAD_W{1'b0}}, r_q.pc};     r_d.st = S_I_WR0;  end
            S_I_WR0:  begin mem_we = 1'b1;                         r_d.st = S_I_MAR1; end
            S_I_MAR1: begin r_d.mar = SAVE_AC;                     r_d.st = S_I_MBR1; end
            S_I_MBR1: begin r_d.mbr = r_q.ac;                      r_d.st = S_I_WR1;  end
            S_I_WR1:  begin mem_we = 1'b1;                         r_d.st = S_I_VEC;  end
            S_I_VEC:  begin r_d.pc = HANDLER; r_d.ie = 1'b0;       r_d.st = S_F_MAR;  end
            S_HALT:   r_d.st = S_HALT;
            default:  r_d.st = S_F_MAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.st  <= S_F_MAR;
            r_q.pc  <= RESET_PC;
            r_q.ie  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_addr = r_q.mar;
    assign mbr_o    = r_q.mbr;
    assign ir_o     = r_q.ir;
    assign ac_o     = r_q.ac;
    assign halted   = (r_q.st == S_HALT);

    AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we)); // R12
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted && !mem_re && !mem_we); // R6
    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_F_INC) |=> (r_q.pc == $past(r_q.pc) + 1'b1)); // R2
    AST_SAVE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && r_q.st == S_I_WR1) |-> (mem_addr == SAVE_AC)); // R8
    AST_HANDLER_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_I_VEC) |=> (r_q.pc == HANDLER && r_q.st == S_F_MAR)); // R8
    AST_IE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_I_VEC) |=> !r_q.ie); // R9
    AST_IE_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_R_AC) |=> r_q.ie); // R10
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12,
    parameter logic [ADDR_W-1:0] RESET_PC = 12'h064,
    parameter logic [ADDR_W-1:0] HANDLER  = 12'h010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_re,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              halted
);
    op_cls_e           op_cls;
    logic [ADDR_W-1:0] op_addr;
    logic [DATA_W-1:0] alu_res, ir, ac, mbr;
    alu_sel_e          alu_sel;

    acc_cpu_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) decode_i (
        .ir(ir), .op_cls(op_cls), .op_addr(op_addr)
    );

    acc_cpu_alu #(.DATA_W(DATA_W)) alu_i (
        .sel(alu_sel), .acc(ac), .opnd(mbr), .res(alu_res)
    );

    acc_cpu_seq #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .RESET_PC(RESET_PC), .HANDLER(HANDLER)
    ) seq_i (
        .clk(clk), .rst_n(rst_n), .irq(irq),
        .op_cls(op_cls), .op_addr(op_addr), .alu_res(alu_res), .alu_sel(alu_sel),
        .ir_o(ir), .ac_o(ac), .mbr_o(mbr),
        .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
        .mem_rdata(mem_rdata), .halted(halted)
    );

    assign mem_wdata = mbr;
endmodule

// File: tb/acc_cpu_tb_top.sv
module acc_cpu_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq = 1'b0;
    logic [11:0] mem_addr;
    logic        mem_re, mem_we, halted;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct {
        logic        we;
        logic [11:0] addr;
        logic [15:0] data;
        string       tag;
    } acc_t;

    acc_t exp_q[$];
    logic [15:0] mem [int];

    always #4 clk = ~clk;

    acc_cpu dut_i (
        .clk(clk), .rst_n(rst_n), .irq(irq),
        .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .halted(halted)
    );

    // synchronous memory model
    always @(posedge clk) begin
        if (mem_re) mem_rdata <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 16'h0000;
        if (mem_we) mem[int'(mem_addr)] = mem_wdata;
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic exp_rd(input logic [11:0] a, input string tag);
        acc_t e;
        e.we = 1'b0; e.addr = a; e.data = '0; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic exp_wr(input logic [11:0] a, input logic [15:0] d, input string tag);
        acc_t e;
        e.we = 1'b1; e.addr = a; e.data = d; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // monitor: compare each memory access against the scoreboard
    always @(negedge clk) begin
        if (rst_n && (mem_re || mem_we)) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6 unexpected access", {3'b0, mem_we, 4'b0, mem_addr, 12'b0}, 32'h0);
            end else begin
                acc_t e;
                e = exp_q.pop_front();
                check((mem_we == e.we) && (mem_addr == e.addr) && (!e.we || mem_wdata == e.data),
                      e.tag, {3'b0, mem_we, mem_addr, mem_wdata}, {3'b0, e.we, e.addr, e.data});
            end
        end
    end

    task automatic do_reset();
        rst_n = 1'b0;
        irq = 1'b0;
        repeat (3) @(negedge clk);
        check(!halted && !mem_re && !mem_we, "R1 reset state",
              {29'b0, halted, mem_re, mem_we}, 32'h0);
    endtask

    task automatic run_to_halt(input string tag);
        int n = 0;
        while (!halted && n < 3000) begin
            @(negedge clk);
            n++;
        end
        check(halted, tag, {31'b0, halted}, 32'h1);
        repeat (40) @(negedge clk);
        check(halted, "R6 halt holds", {31'b0, halted}, 32'h1);
        check(exp_q.size() == 0, "R2 trace complete", exp_q.size(), 32'h0);
    endtask

    initial begin
        // Test 1: load / add / store / stop
        do_reset();
        mem.delete();
        mem[100] = 16'h5068; mem[101] = 16'h1069; mem[102] = 16'h206A; mem[103] = 16'h0000;
        mem[104] = 16'd3; mem[105] = 16'd5;
        exp_rd(12'h064, "R1"); exp_rd(12'h068, "R3");
        exp_rd(12'h065, "R2"); exp_rd(12'h069, "R4");
        exp_rd(12'h066, "R2"); exp_wr(12'h06A, 16'd8, "R5");
        exp_rd(12'h067, "R2");
        @(negedge clk); rst_n = 1'b1;
        run_to_halt("R6 stop halts");
        check(mem[106] == 16'd8, "R5 result word", {16'b0, mem[106]}, 32'd8);

        // Test 2: interrupt, nop, jump, return
        do_reset();
        mem.delete();
        mem[12'h064] = 16'h5200; mem[12'h065] = 16'hF000; mem[12'h066] = 16'h2201;
        mem[12'h067] = 16'h6120; mem[12'h120] = 16'h2202; mem[12'h121] = 16'h0000;
        mem[12'h200] = 16'h0007; mem[12'h203] = 16'h0011;
        mem[12'h010] = 16'h5203; mem[12'h011] = 16'h2204; mem[12'h012] = 16'h7000;
        exp_rd(12'h064, "R1"); exp_rd(12'h200, "R8");
        exp_wr(12'hFFE, 16'h0065, "R8"); exp_wr(12'hFFF, 16'h0007, "R8");
        exp_rd(12'h010, "R8"); exp_rd(12'h203, "R9");
        exp_rd(12'h011, "R9"); exp_wr(12'h204, 16'h0011, "R9");
        exp_rd(12'h012, "R9"); exp_rd(12'hFFE, "R10"); exp_rd(12'hFFF, "R10");
        exp_rd(12'h065, "R10"); exp_rd(12'h066, "R11");
        exp_wr(12'h201, 16'h0007, "R11"); exp_rd(12'h067, "R7");
        exp_rd(12'h120, "R7"); exp_wr(12'h202, 16'h0007, "R10");
        exp_rd(12'h121, "R12");
        @(negedge clk); rst_n = 1'b1; irq = 1'b1;
        begin
            int n = 0;
            while (!(mem_re && mem_addr == 12'hFFE) && n < 3000) begin
                @(negedge clk);
                n++;
            end
            check(n < 3000, "R10 return reached", n, 32'd0);
        end
        irq = 1'b0;
        run_to_halt("R7 program end");
        check(mem[12'h201] == 16'h0007, "R11 acc kept", {16'b0, mem[12'h201]}, 32'h7);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule